// File: doc/BRIEF.md
# Serial Unit Status Flag Controller

This block keeps the five status flags of a clocked serial interface and shows them in one status register. The transmit and receive datapaths send it single-cycle event strobes. These mark a load of the shift register from the transmit data register, the transmission of a frame's last bit, the completion of a receive and the start of a transfer. The datapaths also send a level that is high while a transfer is running.

The datapaths additionally report register-access side effects: a write to the transmit data register and a read of the receive data register. The block takes the transmit-enable level, a four-wire mode select, a master/slave select and the raw chip-select pin.

Software reads the status register at any time. A flag can be cleared only by a status read that saw the flag as 1, followed by a status write that holds 0 in the flag's position. Hardware set events always win over a clear in the same cycle. While an overrun is flagged, the block tells the receive datapath to hold off.

Top module: `sstat_flags`

## Requirements
- R1: After reset every status bit is 0 and `rx_inhibit` is 0. The layout of `rdata` is as follows: bit 7 is transmit-empty, bit 6 is transmit-end, bit 5 is receive-full, bit 2 is overrun and bit 0 is conflict. Bits 1, 3, 4 and all bits above 7 always read 0.
- R2: A status write never sets a flag. A 0 written to a flag that was not seen as 1 by a status read since the last status write leaves the flag unchanged.
- R3: A status read that returns a flag as 1, followed by a status write with 0 in that flag's bit, clears that flag and no other. A side-effect clear between the read and the write cancels that flag's pending permission to clear.
- R4: `ev_rx_done` sets receive-full when no overrun is flagged. `rx_data_rd` clears receive-full.
- R5: `tx_data_wr` clears both transmit-empty and transmit-end.
- R6: Transmit-empty is set on a 0-to-1 change of `tx_en` and on every `ev_load`.
- R7: `ev_last_bit` sets transmit-end only while transmit-empty is 1.
- R8: `ev_rx_done` while receive-full is 1 sets overrun. While overrun is 1, `rx_inhibit` is 1 and `ev_rx_done` does not set receive-full.
- R9: With `four_wire`=1 and `master`=1, `ev_xfer_start` sets conflict if the synchronized chip-select level is low.
- R10: With `four_wire`=1 and `master`=0, a low-to-high change of the synchronized chip-select while `xfer_busy` is 1 sets conflict. With `four_wire`=0, conflict is never set.
- R11: A hardware set event and a permitted software clear of the same flag in one cycle leave the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| st_rd | input | 1 | Status register read strobe |
| st_wr | input | 1 | Status register write strobe |
| wdata | input | REG_W | Status write data |
| rdata | output | REG_W | Status register contents |
| tx_data_wr | input | 1 | Write to the transmit data register |
| rx_data_rd | input | 1 | Read of the receive data register |
| tx_en | input | 1 | Transmit enable level |
| ev_load | input | 1 | Shift register loaded from the transmit data register |
| ev_last_bit | input | 1 | Last bit of a frame transmitted |
| ev_rx_done | input | 1 | Receive completed |
| ev_xfer_start | input | 1 | Transfer starts |
| xfer_busy | input | 1 | Transfer in progress |
| four_wire | input | 1 | Four-wire mode select |
| master | input | 1 | 1 = master, 0 = slave |
| cs_pin | input | 1 | Raw chip-select pin level (idle high) |
| rx_inhibit | output | 1 | Receive blocked while overrun is flagged |

## Verification
The two functions that can fall in the same cycle are a hardware set event and a software clear that is already permitted. The bench arms transmit-empty with a status read. It then drives a status write of 0 in the same clock as an `ev_load` strobe and expects the flag to read 1 afterwards. A second collision covers the side-effect path. A receive-data read cancels a pending clear permission, so a later write of 0 must leave the re-set receive-full flag standing. Sweeps over all 256 write values and all 32 clear masks judge the flag word arithmetically.

// File: rtl/sstat_pkg.sv
package sstat_pkg;
   localparam int NFLAG   = 5;
   localparam int IX_CE   = 0;
   localparam int IX_ORER = 1;
   localparam int IX_RDRF = 2;
   localparam int IX_TEND = 3;
   localparam int IX_TDRE = 4;

   // bit position of each flag in the status word (software decodes these)
   function automatic int flag_pos(input int ix);
      case (ix)
         IX_CE:   return 0;
         IX_ORER: return 2;
         IX_RDRF: return 5;
         IX_TEND: return 6;
         default: return 7;
      endcase
   endfunction
endpackage

// File: rtl/sstat_cs_sync.sv
module sstat_cs_sync #(
   parameter int STAGES = 2,
   parameter bit IDLE   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic lvl,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sstat_cs_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {STAGES{IDLE}};
         prev  <= IDLE;
      end else begin
         chain <= {chain[STAGES-2:0], pin};
         prev  <= chain[STAGES-1];
      end
   end

   assign lvl  = chain[STAGES-1];
   assign rise = lvl & ~prev;
endmodule

// File: rtl/sstat_flag_bit.sv
module sstat_flag_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_ev,
   input  logic side_clr,
   input  logic st_rd,
   input  logic st_wr,
   input  logic wr_bit,
   output logic flag
);
   logic arm;
   logic sw_clr;

   assign sw_clr = st_wr & arm & ~wr_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
         arm  <= 1'b0;
      end else begin
         if (set_ev)                  flag <= 1'b1;
         else if (side_clr || sw_clr) flag <= 1'b0;

         if (st_wr || side_clr)       arm <= 1'b0;
         else if (st_rd && flag)      arm <= 1'b1;
      end
   end

   p_write_one_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr && wr_bit && !side_clr && flag) |=> flag);

   p_unarmed_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr && !arm && !side_clr && flag) |=> flag);

   p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (set_ev && sw_clr) |=> flag);
endmodule

// File: rtl/sstat_flags.sv
module sstat_flags
   import sstat_pkg::*;
#(
   parameter int REG_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit CS_IDLE     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             st_rd,
   input  logic             st_wr,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   input  logic             tx_data_wr,
   input  logic             rx_data_rd,
   input  logic             tx_en,
   input  logic             ev_load,
   input  logic             ev_last_bit,
   input  logic             ev_rx_done,
   input  logic             ev_xfer_start,
   input  logic             xfer_busy,
   input  logic             four_wire,
   input  logic             master,
   input  logic             cs_pin,
   output logic             rx_inhibit
);
   if (REG_W < 8) begin : g_bad_width
      $error("sstat_flags: REG_W must be at least 8");
   end

   logic [NFLAG-1:0] flg;
   logic [NFLAG-1:0] set_v;
   logic [NFLAG-1:0] clr_v;
   logic             cs_lvl, cs_rise;
   logic             tx_en_q;
   logic             unused_wdata;

   assign unused_wdata = ^wdata;

   sstat_cs_sync #(.STAGES(SYNC_STAGES), .IDLE(CS_IDLE)) u_cs (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (cs_pin),
      .lvl  (cs_lvl),
      .rise (cs_rise)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tx_en_q <= 1'b0;
      else        tx_en_q <= tx_en;
   end

   always_comb begin
      set_v          = '0;
      clr_v          = '0;
      set_v[IX_TDRE] = ev_load | (tx_en & ~tx_en_q);
      set_v[IX_TEND] = ev_last_bit & flg[IX_TDRE];
      set_v[IX_RDRF] = ev_rx_done & ~flg[IX_ORER];
      set_v[IX_ORER] = ev_rx_done & flg[IX_RDRF] & ~flg[IX_ORER];
      set_v[IX_CE]   = four_wire & (master ? (ev_xfer_start & ~cs_lvl)
                                           : (xfer_busy & cs_rise));
      clr_v[IX_TDRE] = tx_data_wr;
      clr_v[IX_TEND] = tx_data_wr;
      clr_v[IX_RDRF] = rx_data_rd;
   end

   for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      sstat_flag_bit u_bit (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_ev  (set_v[i]),
         .side_clr(clr_v[i]),
         .st_rd   (st_rd),
         .st_wr   (st_wr),
         .wr_bit  (wdata[flag_pos(i)]),
         .flag    (flg[i])
      );
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NFLAG; i++) rdata[flag_pos(i)] = flg[i];
   end

   assign rx_inhibit = flg[IX_ORER];

   p_rdrf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rx_done && !rx_inhibit) |=> rdata[5]);

   p_rdrf_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_data_rd && !ev_rx_done) |=> !rdata[5]);

   p_tend_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_data_wr && !ev_last_bit) |=> !rdata[6]);

   p_load_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ev_load |=> rdata[7]);

   p_blocked_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_inhibit && ev_rx_done && !rx_data_rd) |=> $stable(rdata[5]));

   p_no_ce_two_wire_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!four_wire && !rdata[0] && !st_wr) |=> !rdata[0]);
endmodule

// File: tb/sstat_flags_test.sv
module sstat_flags_test;
   logic       clk = 0;
   logic       rst_n;
   logic       st_rd, st_wr, tx_data_wr, rx_data_rd, tx_en;
   logic       ev_load, ev_last_bit, ev_rx_done, ev_xfer_start, xfer_busy;
   logic       four_wire, master, cs_pin;
   logic [7:0] wdata;
   logic [7:0] rdata;
   logic       rx_inhibit;
   int         total = 0;
   int         bad = 0;
   logic [7:0] rv;

   localparam logic [7:0] ALL = 8'hE5;

   always #5 clk = ~clk;

   sstat_flags uut (
      .clk(clk), .rst_n(rst_n), .st_rd(st_rd), .st_wr(st_wr), .wdata(wdata),
      .rdata(rdata), .tx_data_wr(tx_data_wr), .rx_data_rd(rx_data_rd),
      .tx_en(tx_en), .ev_load(ev_load), .ev_last_bit(ev_last_bit),
      .ev_rx_done(ev_rx_done), .ev_xfer_start(ev_xfer_start),
      .xfer_busy(xfer_busy), .four_wire(four_wire), .master(master),
      .cs_pin(cs_pin), .rx_inhibit(rx_inhibit)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic do_reset;
      rst_n = 0;
      {st_rd, st_wr, tx_data_wr, rx_data_rd, tx_en} = '0;
      {ev_load, ev_last_bit, ev_rx_done, ev_xfer_start, xfer_busy} = '0;
      {four_wire, master} = '0;
      cs_pin = 1;
      wdata = 0;
      tick(2);
      rst_n = 1;
      tick(1);
   endtask

   // 0 load, 1 last_bit, 2 rx_done, 3 xfer_start, 4 tx_data_wr, 5 rx_data_rd
   task automatic pulse(input int which);
      case (which)
         0: ev_load = 1;
         1: ev_last_bit = 1;
         2: ev_rx_done = 1;
         3: ev_xfer_start = 1;
         4: tx_data_wr = 1;
         default: rx_data_rd = 1;
      endcase
      tick(1);
      {ev_load, ev_last_bit, ev_rx_done, ev_xfer_start, tx_data_wr, rx_data_rd} = '0;
   endtask

   task automatic st_read(output logic [7:0] v);
      st_rd = 1;
      v = rdata;
      tick(1);
      st_rd = 0;
   endtask

   task automatic st_write(input logic [7:0] v);
      st_wr = 1;
      wdata = v;
      tick(1);
      st_wr = 0;
      wdata = 0;
   endtask

   task automatic set_all;
      four_wire = 1; master = 1; cs_pin = 0;
      tick(4);
      pulse(3);
      pulse(0);
      pulse(1);
      pulse(2);
      pulse(2);
   endtask

   function automatic logic [7:0] mask_of(input int m);
      logic [7:0] r = 0;
      r[0] = m[0]; r[2] = m[1]; r[5] = m[2]; r[6] = m[3]; r[7] = m[4];
      return r;
   endfunction

   initial begin
      #2000000;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      do_reset;
      check("R1 reset status", rdata, 8'h00);
      check("R1 reset inhibit", {7'b0, rx_inhibit}, 8'h00);

      // transmit path
      tx_en = 1; tick(1);
      check("R6 tx_en rise sets empty", rdata, 8'h80);
      pulse(1);
      check("R7 last bit with empty sets end", rdata, 8'hC0);
      pulse(4);
      check("R5 tx data write clears empty and end", rdata, 8'h00);
      pulse(1);
      check("R7 last bit without empty", rdata, 8'h00);
      pulse(0);
      check("R6 load sets empty", rdata, 8'h80);

      // receive path
      do_reset;
      pulse(2);
      check("R4 receive sets full", rdata, 8'h20);
      pulse(5);
      check("R4 data read clears full", rdata, 8'h00);
      pulse(2); pulse(2);
      check("R8 overrun set", rdata, 8'h24);
      check("R8 inhibit asserted", {7'b0, rx_inhibit}, 8'h01);
      pulse(5); pulse(2);
      check("R8 receive blocked", rdata, 8'h04);

      // all flags, write without arm: 256 values
      do_reset;
      set_all;
      check("R1 all flags layout", rdata, ALL);
      for (int v = 0; v < 256; v++) begin
         st_write(v[7:0]);
         check("R2 write unarmed no effect", rdata, ALL);
      end

      // clear masks after read
      for (int m = 0; m < 32; m++) begin
         do_reset;
         set_all;
         st_read(rv);
         st_write(ALL & ~mask_of(m));
         check("R3 read-one then write-zero clears", rdata, ALL & ~mask_of(m));
      end

      // intervening write cancels arm
      do_reset;
      set_all;
      st_read(rv);
      st_write(8'hFF);
      st_write(8'h00);
      check("R2 arm dropped by earlier write", rdata, ALL);

      // side-effect clear cancels arm
      do_reset;
      pulse(2);
      st_read(rv);
      pulse(5);
      pulse(2);
      st_write(8'h00);
      check("R3 side clear cancels arm", rdata, 8'h20);

      // set wins over a permitted clear
      do_reset;
      pulse(0);
      st_read(rv);
      st_wr = 1; wdata = 8'h00; ev_load = 1;
      tick(1);
      st_wr = 0; ev_load = 0;
      check("R11 load beats software clear", rdata, 8'h80);

      // master conflict
      do_reset;
      four_wire = 1; master = 1; cs_pin = 0; tick(4);
      pulse(3);
      check("R9 master cs low at start", rdata, 8'h01);
      do_reset;
      four_wire = 1; master = 1; tick(4);
      pulse(3);
      check("R9 master cs high no conflict", rdata, 8'h00);

      // slave conflict
      do_reset;
      four_wire = 1; cs_pin = 0; tick(4);
      xfer_busy = 1; cs_pin = 1; tick(5);
      xfer_busy = 0;
      check("R10 slave cs rise while busy", rdata, 8'h01);
      do_reset;
      four_wire = 1; cs_pin = 0; tick(4);
      cs_pin = 1; tick(5);
      check("R10 slave cs rise while idle", rdata, 8'h00);
      do_reset;
      master = 1; cs_pin = 0; tick(4);
      pulse(3);
      check("R10 two-wire master ignored", rdata, 8'h00);
      do_reset;
      cs_pin = 0; tick(4);
      xfer_busy = 1; cs_pin = 1; tick(5);
      xfer_busy = 0;
      check("R10 two-wire slave ignored", rdata, 8'h00);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule